// File: doc/BRIEF.md
# Spare Processor Reassignment Controller

This block keeps the role table for a fixed pool of physical processing units. Each unit holds a 3-bit role code and a 4-bit logical number. When a unit is reported as checkstopped, the controller retires it and moves its role to a spare unit. A general-type unit passes its logical number to the spare unchanged, so the rest of the system keeps addressing the same logical processor. If the master assist unit fails and no spare is left, the controller takes over the compute unit with the highest logical number and gives up that logical number.

Each failure report is accepted in one cycle. The table update and the outcome event appear on the next cycle. The table can be read at any time through two combinational lookups: one by physical unit and one by logical number.

Role codes are 0 failed, 1 compute, 2 assist, 3 master assist, 4 spare, 5 coupling and 6 hosted. Codes 1, 5 and 6 are the general-type roles that carry a logical number. After reset the layout is as follows. Unit 0 is master assist and unit 1 is assist. Units 2..9 are compute with logical numbers 0..7. Units 10..11 are coupling with logical numbers 8..9. Unit 12 is hosted with logical number 10. Units 13..15 are spare.

Top module: `spare_remap`

## Requirements
- R1: After reset the table holds the layout given above, with logical number 0 for every unit that is not general-type.
- R2: When a compute unit fails and a spare exists, the lowest-numbered spare takes role 1 and the failed unit's logical number. The failed unit reads role 0 with logical number 0.
- R3: Coupling (5) and hosted (6) units are handled exactly like compute units. The spare keeps the same role code and logical number, and a coupling or hosted failure with no spare raises the no-spare event.
- R4: When an assist unit (2) fails, the lowest spare becomes assist. With no spare, only the no-spare event is raised.
- R5: When the master assist unit (3) fails and a spare exists, the lowest spare becomes master assist.
- R6: When the master assist unit fails with no spare, the compute unit with the highest logical number becomes master assist with logical number 0. Its old logical number is no longer mapped. The capacity-lost event is raised and reports that number, together with the no-spare event.
- R7: When a general-type unit fails with no spare, the no-spare event is raised and its logical number is no longer mapped.
- R8: A failed unit is never picked as a spare and never gets a role again. Reporting a spare or an already-failed unit marks it failed and moves no role.
- R9: Each accepted report produces exactly one `evt_done` pulse on the next cycle. The other event outputs are valid only in that cycle. `evt_unit` names the unit that received a role, or 0 if none did.
- R10: The logical lookup reports a hit and the physical unit for any logical number held by a general-type unit. The physical lookup returns the role and logical number of the selected unit.
- R11: `fail_ready` is high whenever reset is released, so one report can be accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fail_valid | input | 1 | Failure report present |
| fail_ready | output | 1 | Report can be accepted |
| fail_unit | input | 4 | Physical unit that checkstopped |
| lk_unit | input | 4 | Physical unit to look up |
| lk_role | output | 3 | Role code of `lk_unit` |
| lk_num | output | 4 | Logical number of `lk_unit` |
| lg_num | input | 4 | Logical number to look up |
| lg_hit | output | 1 | `lg_num` is held by a general-type unit |
| lg_unit | output | 4 | Unit holding `lg_num` |
| evt_done | output | 1 | One-cycle pulse after an accepted report |
| evt_took_spare | output | 1 | A spare received the failed unit's role |
| evt_unit | output | 4 | Unit that received a role |
| evt_no_spare | output | 1 | A role needed a spare and none was left |
| evt_cap_lost | output | 1 | A compute unit was taken over for master assist |
| evt_lost_num | output | 4 | Logical number given up on takeover |

## Verification
The bench runs the spare pool down to nothing and then keeps failing units, so that the no-spare path and the takeover path both run from real table contents.

It also reports failures of a spare unit and of an already-failed unit. A design that only marked roles without removing units from the pool would hand out a dead unit, and the lookup would show a failed unit with a live role.

The master takeover is checked for the compute unit with the highest logical number. A design that searched by physical index would take the wrong unit and report the wrong lost number.

Back-to-back reports check that each one sees the table already updated by the report before it.

// File: rtl/spare_remap.sv
module spare_remap #(
  parameter int N_UNITS  = 16,
  parameter int N_GEN    = 8,
  parameter int N_COUPLE = 2,
  parameter int N_HOSTED = 1,
  parameter int LNUM_W   = 4,
  parameter int ID_W     = $clog2(N_UNITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fail_valid,
  output logic              fail_ready,
  input  logic [ID_W-1:0]   fail_unit,
  input  logic [ID_W-1:0]   lk_unit,
  output logic [2:0]        lk_role,
  output logic [LNUM_W-1:0] lk_num,
  input  logic [LNUM_W-1:0] lg_num,
  output logic              lg_hit,
  output logic [ID_W-1:0]   lg_unit,
  output logic              evt_done,
  output logic              evt_took_spare,
  output logic [ID_W-1:0]   evt_unit,
  output logic              evt_no_spare,
  output logic              evt_cap_lost,
  output logic [LNUM_W-1:0] evt_lost_num
);
  localparam logic [2:0] R_FAILED  = 3'd0;
  localparam logic [2:0] R_COMPUTE = 3'd1;
  localparam logic [2:0] R_ASSIST  = 3'd2;
  localparam logic [2:0] R_MASTER  = 3'd3;
  localparam logic [2:0] R_SPARE   = 3'd4;
  localparam logic [2:0] R_COUPLE  = 3'd5;
  localparam logic [2:0] R_HOSTED  = 3'd6;
  localparam int END_GEN    = 2 + N_GEN;
  localparam int END_COUPLE = END_GEN + N_COUPLE;
  localparam int END_HOSTED = END_COUPLE + N_HOSTED;

  function automatic logic [2:0] init_role(int i);
    if (i == 0)               return R_MASTER;
    else if (i == 1)          return R_ASSIST;
    else if (i < END_GEN)     return R_COMPUTE;
    else if (i < END_COUPLE)  return R_COUPLE;
    else if (i < END_HOSTED)  return R_HOSTED;
    else                      return R_SPARE;
  endfunction

  function automatic logic is_gen(logic [2:0] r);
    return (r == R_COMPUTE) || (r == R_COUPLE) || (r == R_HOSTED);
  endfunction

  logic [2:0]        role_q [N_UNITS];
  logic [LNUM_W-1:0] num_q  [N_UNITS];

  logic              accept, in_rng, needs, spare_hit, take_hit;
  logic [2:0]        vrole;
  logic [LNUM_W-1:0] vnum, take_num;
  logic [ID_W-1:0]   spare_idx, take_idx;
  logic              do_spare, do_take, no_spare;

  assign fail_ready = rst_n;
  assign accept     = fail_valid && fail_ready;
  assign in_rng     = int'(fail_unit) < N_UNITS;
  assign vrole      = in_rng ? role_q[fail_unit] : R_FAILED;
  assign vnum       = in_rng ? num_q[fail_unit] : '0;
  assign needs      = is_gen(vrole) || (vrole == R_ASSIST) || (vrole == R_MASTER);

  always_comb begin
    spare_hit = 1'b0;
    spare_idx = '0;
    for (int i = N_UNITS - 1; i >= 0; i--) begin
      if (role_q[i] == R_SPARE) begin
        spare_hit = 1'b1;
        spare_idx = ID_W'(i);
      end
    end
  end

  always_comb begin
    take_hit = 1'b0;
    take_idx = '0;
    take_num = '0;
    for (int i = 0; i < N_UNITS; i++) begin
      if (role_q[i] == R_COMPUTE && (!take_hit || num_q[i] > take_num)) begin
        take_hit = 1'b1;
        take_idx = ID_W'(i);
        take_num = num_q[i];
      end
    end
  end

  assign do_spare = accept && needs && spare_hit;
  assign do_take  = accept && (vrole == R_MASTER) && !spare_hit && take_hit;
  assign no_spare = accept && needs && !spare_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_UNITS; i++) begin
        role_q[i] <= init_role(i);
        num_q[i]  <= is_gen(init_role(i)) ? LNUM_W'(i - 2) : '0;
      end
    end else if (accept && in_rng) begin
      role_q[fail_unit] <= R_FAILED;
      num_q[fail_unit]  <= '0;
      if (do_spare) begin
        role_q[spare_idx] <= vrole;
        num_q[spare_idx]  <= vnum;
      end
      if (do_take) begin
        role_q[take_idx] <= R_MASTER;
        num_q[take_idx]  <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_done       <= 1'b0;
      evt_took_spare <= 1'b0;
      evt_unit       <= '0;
      evt_no_spare   <= 1'b0;
      evt_cap_lost   <= 1'b0;
      evt_lost_num   <= '0;
    end else begin
      evt_done       <= accept;
      evt_took_spare <= do_spare;
      evt_unit       <= do_spare ? spare_idx : (do_take ? take_idx : '0);
      evt_no_spare   <= no_spare;
      evt_cap_lost   <= do_take;
      evt_lost_num   <= do_take ? take_num : '0;
    end
  end

  assign lk_role = role_q[lk_unit];
  assign lk_num  = num_q[lk_unit];

  always_comb begin
    lg_hit  = 1'b0;
    lg_unit = '0;
    for (int i = N_UNITS - 1; i >= 0; i--) begin
      if (is_gen(role_q[i]) && num_q[i] == lg_num) begin
        lg_hit  = 1'b1;
        lg_unit = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/spare_remap_chk.sv
module spare_remap_chk #(
  parameter int ID_W   = 4,
  parameter int LNUM_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fail_valid,
  input logic              fail_ready,
  input logic [ID_W-1:0]   lk_unit,
  input logic [2:0]        lk_role,
  input logic              evt_done,
  input logic              evt_took_spare,
  input logic              evt_no_spare,
  input logic              evt_cap_lost
);
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_valid && fail_ready) |=> evt_done); // R9
  AST_NO_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fail_valid && fail_ready) |=> !evt_done); // R9
  AST_EVT_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_took_spare || evt_no_spare) |-> evt_done); // R9
  AST_SPARE_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_took_spare && evt_no_spare)); // R2
  AST_TAKEOVER_NOSPARE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cap_lost |-> evt_no_spare); // R6
  AST_READY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    fail_ready); // R11
  AST_DEAD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_role == 3'd0) |=> (!$stable(lk_unit) || lk_role == 3'd0)); // R8
endmodule

bind spare_remap spare_remap_chk #(.ID_W(ID_W), .LNUM_W(LNUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fail_valid(fail_valid), .fail_ready(fail_ready),
  .lk_unit(lk_unit), .lk_role(lk_role), .evt_done(evt_done),
  .evt_took_spare(evt_took_spare), .evt_no_spare(evt_no_spare),
  .evt_cap_lost(evt_cap_lost)
);

// File: tb/spare_remap_bench.sv
module spare_remap_bench;
  localparam int N = 16;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, fail_valid = 1'b0, fail_ready;
  logic [3:0] fail_unit = '0, lk_unit = '0, lk_num, lg_num = '0, lg_unit;
  logic [2:0] lk_role;
  logic lg_hit, evt_done, evt_took_spare, evt_no_spare, evt_cap_lost;
  logic [3:0] evt_unit, evt_lost_num;

  spare_remap u_spare_remap (.*);

  int n_chk = 0, n_bad = 0, sweep = 0;
  int mrole[N], mnum[N];
  bit finished = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit gen_t(int r);
    return r == 1 || r == 5 || r == 6;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      if (i == 0) mrole[i] = 3; else if (i == 1) mrole[i] = 2;
      else if (i < 10) mrole[i] = 1; else if (i < 12) mrole[i] = 5;
      else if (i < 13) mrole[i] = 6; else mrole[i] = 4;
      mnum[i] = gen_t(mrole[i]) ? i - 2 : 0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; fail_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic peek(int u, int r, int num, string req);
    lk_unit = 4'(u); #1;
    chk(req, "lk_role", int'(lk_role), r);
    chk(req, "lk_num", int'(lk_num), num);
  endtask

  task automatic peek_lg(int num, int hit, int u, string req);
    lg_num = 4'(num); #1;
    chk(req, "lg_hit", int'(lg_hit), hit);
    if (hit != 0) chk(req, "lg_unit", int'(lg_unit), u);
  endtask

  task automatic step(bit v, int u, string req);
    int e_sp, e_unit, e_ns, e_cl, e_ln, vr, vn, sp, tk, exp_hit, exp_u;
    fail_valid = v; fail_unit = 4'(u);
    lk_unit = 4'(sweep % N); lg_num = 4'((sweep * 7) % N); sweep++;
    #1;
    chk("R11", "fail_ready", int'(fail_ready), 1);
    chk("R10", "lk_role", int'(lk_role), mrole[sweep - 1 < 0 ? 0 : (sweep - 1) % N]);
    chk("R10", "lk_num", int'(lk_num), mnum[(sweep - 1) % N]);
    exp_hit = 0; exp_u = 0;
    for (int i = N - 1; i >= 0; i--)
      if (gen_t(mrole[i]) && mnum[i] == int'(lg_num)) begin exp_hit = 1; exp_u = i; end
    chk("R10", "lg_hit", int'(lg_hit), exp_hit);
    if (exp_hit != 0) chk("R10", "lg_unit", int'(lg_unit), exp_u);
    e_sp = 0; e_unit = 0; e_ns = 0; e_cl = 0; e_ln = 0;
    if (v) begin
      vr = mrole[u]; vn = mnum[u];
      sp = -1; tk = -1;
      for (int i = 0; i < N; i++) if (sp < 0 && mrole[i] == 4) sp = i;
      for (int i = 0; i < N; i++)
        if (mrole[i] == 1 && (tk < 0 || mnum[i] > mnum[tk])) tk = i;
      mrole[u] = 0; mnum[u] = 0;
      if (gen_t(vr) || vr == 2 || vr == 3) begin
        if (sp >= 0) begin
          e_sp = 1; e_unit = sp; mrole[sp] = vr; mnum[sp] = vn;
        end else begin
          e_ns = 1;
          if (vr == 3 && tk >= 0) begin
            e_cl = 1; e_unit = tk; e_ln = mnum[tk]; mrole[tk] = 3; mnum[tk] = 0;
          end
        end
      end
    end
    @(posedge clk); @(negedge clk);
    fail_valid = 1'b0;
    chk(req, "evt_done", int'(evt_done), int'(v));
    chk(req, "evt_took_spare", int'(evt_took_spare), e_sp);
    chk(req, "evt_unit", int'(evt_unit), e_unit);
    chk(req, "evt_no_spare", int'(evt_no_spare), e_ns);
    chk(req, "evt_cap_lost", int'(evt_cap_lost), e_cl);
    chk(req, "evt_lost_num", int'(evt_lost_num), e_ln);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset layout
    peek(0, 3, 0, "R1"); peek(1, 2, 0, "R1"); peek(2, 1, 0, "R1");
    peek(9, 1, 7, "R1"); peek(10, 5, 8, "R1"); peek(12, 6, 10, "R1");
    peek(15, 4, 0, "R1");
    chk("R9", "evt_done idle", int'(evt_done), 0);
    step(1, 3, "R2");
    peek(3, 0, 0, "R2"); peek(13, 1, 1, "R2"); peek_lg(1, 1, 13, "R10");
    step(1, 10, "R3");
    peek(14, 5, 8, "R3");
    step(1, 1, "R4");
    peek(15, 2, 0, "R4");
    step(1, 3, "R8");
    peek(3, 0, 0, "R8");
    step(0, 0, "R9");
    step(1, 4, "R7");
    peek_lg(2, 0, 0, "R7");
    step(1, 0, "R6");
    peek(9, 3, 0, "R6"); peek_lg(7, 0, 0, "R6");
    step(1, 12, "R3");
    step(1, 15, "R4");
    step(1, 9, "R6");
    step(1, 14, "R7");
    do_reset();
    step(1, 14, "R8");
    peek(14, 0, 0, "R8");
    step(1, 0, "R5");
    peek(13, 3, 0, "R5");
    step(1, 1, "R4");
    step(1, 2, "R7");
    step(1, 13, "R6");
    peek(9, 3, 0, "R6");
    step(1, 14, "R8");
    for (int k = 0; k < 20; k++) step(0, 0, "R9");
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule